// File: doc/BRIEF.md
# Streaming Dot-Product Engine with Rotating Partial Sums

The engine computes the inner product of two unsigned integer vectors that arrive one element pair per clock. A command gives the vector length, and then pairs are accepted on each clock where the stream marks them valid. Every accepted pair goes through a multiplier with a fixed number of register stages. The resulting product then enters an adder ring. The ring's last register feeds back into its first register, so the ring carries one partial sum per stage. Products that arrive in consecutive clocks therefore add into different partial sums, and no product has to wait for the previous addition to finish.

Once the last product has entered the ring, a reduction adds the partial sums in a single step. The engine then raises a one-clock completion pulse and holds the total on its result port until the next completion. Gaps in the valid stream are allowed. Any length from zero to the configured maximum gives the exact sum, because the accumulator is wide enough to hold the largest possible total.

Top module: `dotprod_pipe`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all zero.
- R2: While busy_o is low, start_i captures len_i (0 to MAX_LEN), and busy_o is high from the next clock on.
- R3: While busy_o is high, start_i is ignored. The length already captured and the result of the running job are unaffected.
- R4: A pair is taken only on a clock where busy_o is high, elem_valid_i is high and fewer than the captured length have been taken. Valid pairs offered in any other clock do not change the result.
- R5: result_o equals the exact unsigned sum of a_i*b_i over the taken pairs. It is 2*W + clog2(MAX_LEN+1) bits wide, so the all-ones inputs at the maximum length do not overflow.
- R6: done_o is high for exactly one clock. busy_o falls on the same edge where done_o rises, and result_o keeps its value until the next done_o.
- R7: done_o rises on the (MUL_STAGES+1)-th rising edge after the edge that took the last pair.
- R8: A length of zero raises done_o on the first edge after the start edge, with result_o equal to zero.
- R9: Lengths of 1, 2 and 3, lengths that are not multiples of the ring depth, and streams with idle gaps all give the correct sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| len_i | input | clog2(MAX_LEN+1) | Number of pairs for the command |
| elem_valid_i | input | 1 | a_i/b_i hold a pair |
| a_i | input | W | First vector element, unsigned |
| b_i | input | W | Second vector element, unsigned |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | 2*W+clog2(MAX_LEN+1) | Dot product of the last completed job |

## Verification
The assertions assume that a command is issued only with a length no larger than MAX_LEN, and that the clock and reset are clean. They do not assume that the element stream is well behaved. The stimulus follows this: every command length is drawn from 0 to MAX_LEN. The stream, however, breaks the protocol on purpose. It offers pairs while the engine is idle, keeps offering them after the job has taken its full count, and re-issues start in the middle of a job. This shows that the rules for taking pairs hold up against a careless producer.

// File: rtl/dp_pkg.sv
package dp_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dp_state_e;
endpackage

// File: rtl/dp_mul_pipe.sv
module dp_mul_pipe #(
   parameter int W      = 16,
   parameter int STAGES = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic           out_vld_o,
   output logic [2*W-1:0] out_prod_o
);
   localparam int PW = 2 * W;

   logic [STAGES-1:0]         vld_q;
   logic [STAGES-1:0][PW-1:0] prod_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_seg
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[0]  <= 1'b0;
               prod_q[0] <= '0;
            end else begin
               vld_q[0]  <= in_vld_i;
               prod_q[0] <= in_vld_i ? a_i * b_i : '0;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[s]  <= 1'b0;
               prod_q[s] <= '0;
            end else begin
               vld_q[s]  <= vld_q[s-1];
               prod_q[s] <= prod_q[s-1];
            end
         end
      end
   end

   assign out_vld_o  = vld_q[STAGES-1];
   assign out_prod_o = prod_q[STAGES-1];
endmodule

// File: rtl/dp_acc_ring.sv
module dp_acc_ring #(
   parameter int PW    = 32,
   parameter int AW    = 39,
   parameter int LANES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear_i,
   input  logic                      add_vld_i,
   input  logic [PW-1:0]             add_val_i,
   output logic [LANES-1:0][AW-1:0]  lanes_o
);
   logic [LANES-1:0][AW-1:0] ring_q;
   logic [AW-1:0]            addend;

   assign addend = add_vld_i ? {{(AW-PW){1'b0}}, add_val_i} : '0;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ring_q[0] <= '0;
            else if (clear_i) ring_q[0] <= '0;
            else              ring_q[0] <= ring_q[LANES-1] + addend;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ring_q[l] <= '0;
            else if (clear_i) ring_q[l] <= '0;
            else              ring_q[l] <= ring_q[l-1];
         end
      end
   end

   assign lanes_o = ring_q;

   // R2
   ring_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (lanes_o == '0));
endmodule

// File: rtl/dp_reduce.sv
module dp_reduce #(
   parameter int AW    = 39,
   parameter int LANES = 4
) (
   input  logic [LANES-1:0][AW-1:0] lanes_i,
   output logic [AW-1:0]            sum_o
);
   if (LANES == 1) begin : g_pass
      assign sum_o = lanes_i[0];
   end else begin : g_sum
      always_comb begin
         sum_o = '0;
         for (int i = 0; i < LANES; i++) sum_o = sum_o + lanes_i[i];
      end
   end
endmodule

// File: rtl/dotprod_pipe.sv
module dotprod_pipe #(
   parameter int W          = 16,
   parameter int MAX_LEN    = 64,
   parameter int MUL_STAGES = 4,
   parameter int ADD_STAGES = 4,
   localparam int LW = $clog2(MAX_LEN + 1),
   localparam int AW = 2 * W + LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [LW-1:0] len_i,
   input  logic          elem_valid_i,
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [AW-1:0] result_o
);
   import dp_pkg::*;

   localparam int PW = 2 * W;

   if (W < 1 || MAX_LEN < 1 || MUL_STAGES < 1 || ADD_STAGES < 1) begin : g_bad_cfg
      $error("dotprod_pipe: widths, length and stage counts must be positive");
   end

   dp_state_e                     state_q;
   logic [LW-1:0]                 len_q, acc_cnt, prod_cnt;
   logic                          done_q;
   logic [AW-1:0]                 result_q;
   logic                          take, clear, mul_vld;
   logic [PW-1:0]                 mul_prod;
   logic [ADD_STAGES-1:0][AW-1:0] lanes;
   logic [AW-1:0]                 red_sum;

   assign take  = (state_q == ST_RUN) && elem_valid_i && (acc_cnt < len_q);
   assign clear = (state_q == ST_IDLE) && start_i;

   dp_mul_pipe #(.W(W), .STAGES(MUL_STAGES)) u_mul (
      .clk(clk), .rst_n(rst_n), .in_vld_i(take), .a_i(a_i), .b_i(b_i),
      .out_vld_o(mul_vld), .out_prod_o(mul_prod));

   dp_acc_ring #(.PW(PW), .AW(AW), .LANES(ADD_STAGES)) u_ring (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .add_vld_i(mul_vld),
      .add_val_i(mul_prod), .lanes_o(lanes));

   dp_reduce #(.AW(AW), .LANES(ADD_STAGES)) u_red (
      .lanes_i(lanes), .sum_o(red_sum));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         len_q    <= '0;
         acc_cnt  <= '0;
         prod_cnt <= '0;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q  <= ST_RUN;
                  len_q    <= len_i;
                  acc_cnt  <= '0;
                  prod_cnt <= '0;
               end
            end
            default: begin
               if (take)    acc_cnt  <= acc_cnt + LW'(1);
               if (mul_vld) prod_cnt <= prod_cnt + LW'(1);
               if (prod_cnt == len_q) begin
                  result_q <= red_sum;
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign busy_o   = (state_q == ST_RUN);
   assign done_o   = done_q;
   assign result_o = result_q;

   // R2
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |-> (len_i <= LW'(MAX_LEN)));
   // R3
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(len_q));
   // R4
   take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (acc_cnt <= len_q));
   // R7
   prod_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (prod_cnt <= acc_cnt));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R6
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
endmodule

// File: tb/dotprod_pipe_tb.sv
module dotprod_pipe_tb;
   localparam int W       = 16;
   localparam int MAX_LEN = 64;
   localparam int NM      = 4;
   localparam int LW      = $clog2(MAX_LEN + 1);
   localparam int AW      = 2 * W + LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [LW-1:0] len_i = '0;
   logic          elem_valid_i = 1'b0;
   logic [W-1:0]  a_i = '0, b_i = '0;
   logic          busy_o, done_o;
   logic [AW-1:0] result_o;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   string cur_req = "R1";
   bit    finished = 0;

   // reference model state
   bit     m_busy = 0, m_done = 0;
   int     m_len = 0, m_cnt = 0, m_wait = -1;
   longint m_sum = 0, m_res = 0;
   int unsigned seed = 32'h1234_5678;

   always #4 clk = ~clk;

   dotprod_pipe #(.W(W), .MAX_LEN(MAX_LEN), .MUL_STAGES(NM), .ADD_STAGES(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .elem_valid_i(elem_valid_i), .a_i(a_i), .b_i(b_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o));

   always @(posedge clk) begin
      if (rst_n) begin
         m_done = 0;
         if (m_busy) begin
            if (m_wait == 1) begin
               m_done = 1; m_res = m_sum; m_busy = 0; m_wait = -1;
            end else if (m_wait > 1) begin
               m_wait--;
            end else if (elem_valid_i && m_cnt < m_len) begin
               m_cnt++;
               m_sum += longint'(a_i) * longint'(b_i);
               if (m_cnt == m_len) m_wait = NM + 1;
            end
         end else if (start_i) begin
            m_busy = 1; m_len = int'(len_i); m_cnt = 0; m_sum = 0;
            m_wait = (m_len == 0) ? 1 : -1;
         end
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         chk(cur_req == "R3" ? "R3" : "R2", "busy_o", longint'(busy_o), longint'(m_busy));
         chk(cur_req == "R8" ? "R8" : "R7", "done_o", longint'(done_o), longint'(m_done));
         chk(cur_req, "result_o", longint'(result_o), m_res);
      end
      if (cyc > 150000 && !finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic logic [W-1:0] nxt(input bit maxed);
      seed = seed * 32'd1103515245 + 32'd12345;
      return maxed ? {W{1'b1}} : W'(seed >> 9);
   endfunction

   // Issues a command and streams pairs; gap_mod>0 inserts idle clocks,
   // extra keeps valid high beyond the length (R4), restart re-issues start (R3).
   task automatic job(input int len, input int gap_mod, input int extra,
                      input bit restart, input bit maxed);
      @(negedge clk);
      start_i = 1'b1; len_i = LW'(len);
      @(negedge clk);
      start_i = 1'b0; len_i = '0;
      for (int i = 0; i < len; i++) begin
         if (gap_mod > 0 && (i % gap_mod) == 1) begin
            elem_valid_i = 1'b0;
            @(negedge clk);
         end
         elem_valid_i = 1'b1; a_i = nxt(maxed); b_i = nxt(maxed);
         start_i = restart && (i == 0);
         len_i = restart ? LW'(MAX_LEN) : '0;
         @(negedge clk);
         start_i = 1'b0; len_i = '0;
      end
      for (int i = 0; i < extra; i++) begin
         elem_valid_i = 1'b1; a_i = nxt(0); b_i = nxt(0);
         @(negedge clk);
      end
      elem_valid_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", "reset busy_o", longint'(busy_o), 0);
      chk("R1", "reset done_o", longint'(done_o), 0);
      chk("R1", "reset result_o", longint'(result_o), 0);
      rst_n = 1'b1;
      // R4: valid pairs while idle must not count
      elem_valid_i = 1'b1; a_i = 16'd7; b_i = 16'd9;
      cur_req = "R4";
      repeat (3) @(negedge clk);
      elem_valid_i = 1'b0;
      cur_req = "R5"; job(8, 0, 0, 0, 0);
      job(16, 0, 0, 0, 0);
      cur_req = "R9"; job(1, 0, 0, 0, 0);
      job(2, 0, 0, 0, 0);
      job(3, 0, 0, 0, 0);
      job(5, 3, 0, 0, 0);
      job(13, 2, 0, 0, 0);
      cur_req = "R8"; job(0, 0, 0, 0, 0);
      cur_req = "R3"; job(6, 0, 0, 1, 0);
      cur_req = "R4"; job(7, 0, 5, 0, 0);
      cur_req = "R5"; job(MAX_LEN, 0, 0, 0, 1);
      cur_req = "R6";
      // back-to-back: start asserted on the cycle done_o is high
      @(negedge clk); start_i = 1'b1; len_i = LW'(2);
      @(negedge clk); start_i = 1'b0;
      elem_valid_i = 1'b1; a_i = 16'd3; b_i = 16'd4; @(negedge clk);
      a_i = 16'd5; b_i = 16'd6; @(negedge clk);
      elem_valid_i = 1'b0;
      while (!done_o) @(negedge clk);
      start_i = 1'b1; len_i = LW'(1);
      @(negedge clk); start_i = 1'b0;
      chk("R6", "result held after done", longint'(result_o), 42);
      elem_valid_i = 1'b1; a_i = 16'd10; b_i = 16'd10; @(negedge clk);
      elem_valid_i = 1'b0;
      while (busy_o) @(negedge clk);
      chk("R6", "second result", longint'(result_o), 100);
      repeat (3) @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule